// File: doc/BRIEF.md
# Streaming Gradient Edge Detector with Selectable Kernel

The block takes 8-bit grayscale pixels in raster order, one per cycle when the valid strobe is high, and marks each interior pixel as edge or background. Two line buffers and a 3x3 register window assemble the neighbourhood around a centre pixel that lies one line and one pixel behind the newest input. Two identical shift-and-add units form the horizontal and vertical gradients. A select bit picks either the unit-weight kernel (Prewitt) or the centre-doubled kernel (Sobel). The absolute gradients are summed, clamped to 8 bits and compared with a threshold.

Frames are delimited by a start-of-frame flag on the first pixel. The kernel select and the threshold are captured with that pixel only, so every frame uses one setting. A small controller has three states. `ST_IDLE` is the state after reset, and no pixel is processed in it. `ST_PRIME` counts the first 2W+2 pixels of a frame while the line buffers fill. `ST_STREAM` emits one result per accepted pixel. The transitions are: `ST_IDLE`→`ST_PRIME` on a start-of-frame pixel; `ST_PRIME`→`ST_STREAM` on the (2W+2)-th pixel; `ST_STREAM`→`ST_PRIME` and `ST_PRIME`→`ST_PRIME` on any new start-of-frame pixel.

Top module: `edge_detect`

## Requirements
- R1: A pixel is accepted only in a cycle with `pix_valid` high, and a pixel accepted with `sof` high is row 0, column 0 of a new frame.
- R2: Counting the start-of-frame pixel as index 0, pixel n of a frame with n ≥ 2W+2 produces exactly one output result. Results come out in acceptance order, and each refers to the centre at raster index n−W−1. Pixels with a lower index produce no result.
- R3: With `kern_sel`=0 (Prewitt), Gx is the sum of the lower window row minus the sum of the upper window row. Gy is the sum of the right column minus the sum of the left column.
- R4: With `kern_sel`=1 (Sobel), the middle tap of each summed row or column is weighted by 2, and all other taps are weighted by 1.
- R5: The magnitude is |Gx|+|Gy|, clamped to 255.
- R6: A result is an edge only when the magnitude is strictly greater than the threshold. Edge is output as 0x00 and background as 0xFF.
- R7: A centre in column 0 or in column W−1 is always output as 0xFF.
- R8: `kern_sel` and `thresh` are used only as sampled with the start-of-frame pixel. Changes at any later point of the frame have no effect on that frame's results.
- R9: After reset `out_valid` is low, and accepted pixels produce no output until a start-of-frame pixel arrives.
- R10: A start-of-frame pixel in the middle of a frame restarts the priming count. Results of the old frame that are already in flight still emerge, with the old settings.
- R11: The controller moves between `ST_IDLE`, `ST_PRIME` and `ST_STREAM` only by the transitions named above, and no result is in flight while it is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Marks the accepted pixel as the first of a frame |
| pix_valid | input | 1 | Input pixel strobe |
| pix_in | input | PIX_W | Grayscale input pixel |
| kern_sel | input | 1 | 0 = Prewitt weights, 1 = Sobel weights |
| thresh | input | PIX_W | Edge threshold (strict greater-than) |
| out_valid | output | 1 | Result strobe |
| out_pix | output | PIX_W | 0x00 for edge, 0xFF for background |

## Verification
A wrong column pointer or a line buffer write that lands on the wrong address corrupts the window. This shows up as wrong edge values on the first results of a frame, 2W+2 pixels after its start, so every frame is compared result by result against a model computed from the image. A miscounted priming state changes the number of results. Any missing or extra result therefore appears as a queue mismatch within the same frame. A setting register that follows the inputs after the start of a frame shows up on the next result, because the bench changes both inputs randomly in the middle of frames.

// File: rtl/edge_pkg.sv
package edge_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } edge_state_t;

    typedef enum logic {
        KERN_PREWITT = 1'b0,
        KERN_SOBEL   = 1'b1
    } kern_t;
endpackage

// File: rtl/edge_window.sv
module edge_window #(
    parameter int IMG_W = 16,
    parameter int PIX_W = 8,
    parameter int CW    = $clog2(IMG_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift,
    input  logic [CW-1:0]           wr_col,
    input  logic [PIX_W-1:0]        pix_in,
    output logic [8:0][PIX_W-1:0]   win
);
    logic [PIX_W-1:0] line_a [IMG_W];   // one line back
    logic [PIX_W-1:0] line_b [IMG_W];   // two lines back
    logic [PIX_W-1:0] tap_q  [3][3];
    logic [PIX_W-1:0] src    [3];

    assign src[0] = line_b[wr_col];
    assign src[1] = line_a[wr_col];
    assign src[2] = pix_in;

    always_ff @(posedge clk) begin
        if (shift) begin
            line_a[wr_col] <= pix_in;
            line_b[wr_col] <= line_a[wr_col];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    tap_q[r][c] <= '0;
        end else if (shift) begin
            for (int r = 0; r < 3; r++) begin
                tap_q[r][0] <= tap_q[r][1];
                tap_q[r][1] <= tap_q[r][2];
                tap_q[r][2] <= src[r];
            end
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign win[r*3+c] = tap_q[r][c];
        end
    end
endmodule

// File: rtl/edge_grad.sv
module edge_grad #(
    parameter int PIX_W = 8,
    parameter int GW    = PIX_W + 3
) (
    input  logic [PIX_W-1:0]     pos_a,
    input  logic [PIX_W-1:0]     pos_m,
    input  logic [PIX_W-1:0]     pos_b,
    input  logic [PIX_W-1:0]     neg_a,
    input  logic [PIX_W-1:0]     neg_m,
    input  logic [PIX_W-1:0]     neg_b,
    input  logic                 double_mid,
    output logic signed [GW-1:0] grad
);
    logic [GW-1:0] sum_p, sum_n, mid_p, mid_n;

    always_comb begin
        mid_p = double_mid ? (GW'(pos_m) << 1) : GW'(pos_m);
        mid_n = double_mid ? (GW'(neg_m) << 1) : GW'(neg_m);
        sum_p = GW'(pos_a) + mid_p + GW'(pos_b);
        sum_n = GW'(neg_a) + mid_n + GW'(neg_b);
        grad  = $signed(sum_p) - $signed(sum_n);
    end
endmodule

// File: rtl/edge_detect.sv
module edge_detect
    import edge_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             kern_sel,
    input  logic [PIX_W-1:0] thresh,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam int CW      = $clog2(IMG_W);
    localparam int PRIME_N = 2 * IMG_W + 2;
    localparam int PCW     = $clog2(PRIME_N + 1);
    localparam int GW      = PIX_W + 3;
    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    edge_state_t state_q, state_d;
    logic [CW-1:0]   col_q, cur_col;
    logic [PCW-1:0]  cnt_q, cur_cnt;
    logic            start, emit, border;
    kern_t           kern_q, k0;
    logic [PIX_W-1:0] thr_q, t0, t1, t2;
    logic            v0, v1, v2, b0, b1, b2;
    logic [8:0][PIX_W-1:0] win;
    logic signed [GW-1:0] gx_c, gy_c, gx_q, gy_q;
    logic [GW-1:0]   ax, ay;
    logic [GW:0]     msum;
    logic [PIX_W-1:0] mag_q;

    // Controller: next-state logic
    always_comb begin
        start   = pix_valid && sof;
        cur_col = start ? '0 : col_q;
        cur_cnt = start ? '0 : cnt_q;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PRIME;
            ST_PRIME:  if (pix_valid && cur_cnt == PCW'(PRIME_N - 1)) state_d = ST_STREAM;
            ST_STREAM: if (start) state_d = ST_PRIME;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Controller: outputs
    always_comb begin
        emit   = pix_valid && !start && (state_q == ST_STREAM);
        border = (cur_col <= CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            cnt_q  <= '0;
            kern_q <= KERN_PREWITT;
            thr_q  <= '0;
        end else if (pix_valid) begin
            col_q <= (cur_col == CW'(IMG_W - 1)) ? '0 : cur_col + CW'(1);
            cnt_q <= cur_cnt + PCW'(1);
            if (start) begin
                kern_q <= kern_t'(kern_sel);
                thr_q  <= thresh;
            end
        end
    end

    edge_window #(.IMG_W(IMG_W), .PIX_W(PIX_W), .CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(pix_valid), .wr_col(cur_col),
        .pix_in(pix_in), .win(win)
    );

    // Horizontal gradient: lower row minus upper row
    edge_grad #(.PIX_W(PIX_W), .GW(GW)) u_gx (
        .pos_a(win[6]), .pos_m(win[7]), .pos_b(win[8]),
        .neg_a(win[0]), .neg_m(win[1]), .neg_b(win[2]),
        .double_mid(k0 == KERN_SOBEL), .grad(gx_c)
    );
    // Vertical gradient: same structure, window transposed
    edge_grad #(.PIX_W(PIX_W), .GW(GW)) u_gy (
        .pos_a(win[2]), .pos_m(win[5]), .pos_b(win[8]),
        .neg_a(win[0]), .neg_m(win[3]), .neg_b(win[6]),
        .double_mid(k0 == KERN_SOBEL), .grad(gy_c)
    );

    always_comb begin
        ax   = gx_q[GW-1] ? GW'(-gx_q) : GW'(gx_q);
        ay   = gy_q[GW-1] ? GW'(-gy_q) : GW'(gy_q);
        msum = {1'b0, ax} + {1'b0, ay};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
            b0 <= 1'b0; b1 <= 1'b0; b2 <= 1'b0;
            k0 <= KERN_PREWITT;
            t0 <= '0; t1 <= '0; t2 <= '0;
            gx_q <= '0; gy_q <= '0; mag_q <= '0;
            out_pix <= PIX_MAX;
        end else begin
            // stage 0: window update happens in u_win
            v0 <= emit;
            if (pix_valid) begin
                b0 <= border;
                k0 <= start ? kern_t'(kern_sel) : kern_q;
                t0 <= start ? thresh : thr_q;
            end
            // stage 1: masking
            v1 <= v0; b1 <= b0; t1 <= t0;
            gx_q <= gx_c; gy_q <= gy_c;
            // stage 2: combining with saturation
            v2 <= v1; b2 <= b1; t2 <= t1;
            mag_q <= (msum > (GW+1)'(PIX_MAX)) ? PIX_MAX : msum[PIX_W-1:0];
            // stage 3: threshold
            out_valid <= v2;
            out_pix   <= (!b2 && mag_q > t2) ? '0 : PIX_MAX;
        end
    end

    assert_border_white_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && b2) |=> (out_valid && out_pix == PIX_MAX));

    assert_settings_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !sof) |=> ($stable(kern_q) && $stable(thr_q)));

    assert_idle_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!v0 && !v1 && !v2 && !out_valid));

    assert_emit_from_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v0 |-> ($past(state_q) == ST_STREAM && $past(pix_valid)));

    assert_out_follows_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(v2));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && sof) |=> (state_q == ST_PRIME));
endmodule

// File: tb/edge_detect_test.sv
module edge_detect_test;
    localparam int W = 8;
    localparam int PRIME = 2 * W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0, pix_valid = 1'b0, kern_sel = 1'b0;
    logic [7:0] pix_in = '0, thresh = '0;
    logic out_valid;
    logic [7:0] out_pix;

    int n_chk = 0, n_bad = 0;
    int img [256];
    byte unsigned exp_q [$];
    string tag_q [$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_detect #(.IMG_W(W), .PIX_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .pix_valid(pix_valid), .pix_in(pix_in),
        .kern_sel(kern_sel), .thresh(thresh), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int absi(int v);
        return v < 0 ? -v : v;
    endfunction

    // Model: R3, R4 gradients; R5 magnitude; R6 compare; R7 border
    function automatic byte unsigned ref_px(int m, bit sob, int thr);
        int k, gx, gy, mag, cc;
        cc = m % W;
        if (cc == 0 || cc == W - 1) return 8'hFF;
        k  = sob ? 2 : 1;
        gx = img[m+W-1] + k*img[m+W] + img[m+W+1] - (img[m-W-1] + k*img[m-W] + img[m-W+1]);
        gy = img[m-W+1] + k*img[m+1] + img[m+W+1] - (img[m-W-1] + k*img[m-1] + img[m+W-1]);
        mag = absi(gx) + absi(gy);
        if (mag > 255) mag = 255;
        return (mag > thr) ? 8'h00 : 8'hFF;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 (unexpected output)", out_pix, -1);
            end else begin
                byte unsigned e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_pix == e, t, out_pix, e);
            end
        end
    end

    // pattern: 0 random, 1 flat, 2 ramp, 3 vertical step
    task automatic send_frame(int npix, int pat, bit sob, int thr, bit mix, string tag);
        for (int n = 0; n < npix; n++) begin
            case (pat)
                0: img[n] = $urandom % 256;
                1: img[n] = 77;
                2: img[n] = (n % W) * 8;
                default: img[n] = ((n % W) >= 4) ? 255 : 0;
            endcase
        end
        // R2: one result for each pixel from index 2W+2 on
        for (int n = PRIME; n < npix; n++) begin
            int m;
            m = n - W - 1;
            exp_q.push_back(ref_px(m, sob, thr));
            tag_q.push_back(((m % W) == 0 || (m % W) == W - 1) ? "R7" : tag);
        end
        for (int n = 0; n < npix; n++) begin
            @(negedge clk);
            while ($urandom % 4 == 0) begin
                pix_valid = 1'b0; sof = 1'b0;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_in    = img[n][7:0];
            sof       = (n == 0);
            if (n == 0) begin
                kern_sel = sob; thresh = thr[7:0];
            end else if (mix) begin
                kern_sel = $urandom % 2; thresh = $urandom % 256;  // R8
            end
        end
        @(negedge clk);
        pix_valid = 1'b0; sof = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 after reset", out_valid, 0);
        // R9, R1: pixels before any start-of-frame are ignored
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pix_valid = 1'b1; pix_in = $urandom % 256; sof = 1'b0;
        end
        @(negedge clk); pix_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(out_valid == 1'b0 && exp_q.size() == 0, "R9 no sof", out_valid, 0);

        send_frame(6*W, 0, 1'b0, 60, 1'b1, "R3");       // R3, R8
        send_frame(7*W, 0, 1'b1, 100, 1'b1, "R4");      // R4, R8
        send_frame(5*W, 1, 1'b0, 0, 1'b0, "R6");        // R6 strict at zero
        send_frame(5*W, 2, 1'b0, 48, 1'b0, "R6");       // magnitude 48, not edge
        send_frame(5*W, 2, 1'b0, 47, 1'b0, "R6");       // magnitude 48, edge
        send_frame(5*W, 2, 1'b1, 50, 1'b0, "R4");       // Sobel gives 64
        send_frame(5*W, 3, 1'b0, 254, 1'b0, "R5");      // clamped to 255 > 254
        send_frame(5*W, 3, 1'b1, 255, 1'b0, "R5");      // clamp never exceeds 255
        send_frame(PRIME + 4, 0, 1'b1, 30, 1'b0, "R10"); // aborted frame
        send_frame(6*W, 0, 1'b0, 90, 1'b1, "R10");
        for (int f = 0; f < 6; f++)
            send_frame((4 + $urandom % 5) * W, 0, $urandom % 2, $urandom % 256, 1'b1, "R2");
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R2 result count", exp_q.size(), 0);
        check(out_valid == 1'b0, "R11 drained", out_valid, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule